// File: doc/BRIEF.md
# Banked-Direction Bidirectional I/O Port

This block is an eight-bit general-purpose I/O port for a small controller. Each pin is set as an input or an output by one bit of a direction register. The direction register and the port data register sit at the same bus offset, and a bank-select input chooses between them. Two more registers sit at their own offsets. One holds per-pin pullup enables. The other sets per-pin wired-OR (open-drain) mode for the upper pins. The four lowest pins are always open-drain when they act as outputs.

The block gives an external pad model four signals for each pin: output value, output enable, open-drain flag and pullup enable. Other subsystems can take over individual pins through hook inputs. A parameter mask chooses which pins may be taken over; by default pins 0 to 6 can be, and pin 7 cannot. Pin levels pass through a two-flop synchronizer before they can be read.

Top module: `gpio_bank_port`

## Requirements
- R1: A pin whose direction bit is 1 and which is not claimed is an output. In push-pull mode it has `pad_oe`=1 and `pad_out` equal to its data bit. A pin whose direction bit is 0 and which is not claimed has `pad_oe`=0. For push-pull pins, `pad_out` always follows the data bit.
- R2: At offset 0, `bus_map_sel`=1 reaches the direction register and `bus_map_sel`=0 reaches the data register, for both reads and writes. A write to one bank leaves the other bank unchanged.
- R3: After a synchronous reset (`rst_n`=0 at a rising edge), the direction, pullup and wired-OR registers are all zero. Every `pad_oe` and every `pad_pu_en` is then 0.
- R4: Reset does not change the data register.
- R5: Pins 0 to 3 always have `pad_od`=1. For an open-drain pin, `pad_out` is 0, and `pad_oe` is 1 only when the pin is driven and its value is 0.
- R6: Bit i of the register at offset 2 makes pin i open-drain, so `pad_od[i]` = 1 for i = 0..3 and the bit's value otherwise. The register reads back what was written.
- R7: Bit i of the register at offset 1 enables the pullup for pin i. `pad_pu_en[i]` is that bit ANDed with NOT `pad_oe[i]`. The register reads back what was written.
- R8: A pin whose bit is set in `CLAIM_MASK` (default 0x7F) and whose `hook_en` bit is 1 is claimed. For a claimed pin, `hook_oe` replaces the direction bit and `hook_out` replaces the data bit, and the open-drain rules of R5/R6 still apply. For a pin outside the mask, its hook inputs have no effect.
- R9: A read of the data bank returns, per bit, the data bit for unclaimed output pins and the synchronized pin level for all other pins. A change on `pin_in` shows up in the read value after the second rising edge.
- R10: Offset 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_map_sel | input | 1 | Bank select at offset 0 (1 = direction) |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels from pads (asynchronous) |
| hook_en | input | 8 | Per-pin claim request from subsystems |
| hook_oe | input | 8 | Subsystem drive request per pin |
| hook_out | input | 8 | Subsystem output value per pin |
| pad_out | output | 8 | Value to drive on each pad |
| pad_oe | output | 8 | Pad output enable |
| pad_od | output | 8 | Pad is in open-drain mode |
| pad_pu_en | output | 8 | Pad pullup enable |

## Verification
The assertions assume that `bus_addr`, `bus_map_sel` and `bus_wr_data` are stable and known whenever `bus_wr_en` is high. They also assume that the hook inputs change only between clock edges. The synchronizer-latency property assumes that `pin_in` is sampled cleanly, so it is not changing at the edge. The bench drives every input shortly after the falling edge and holds it through the next rising edge, so each input is settled when it is sampled. Pin levels change only while the bench is waiting on known edges, which keeps the two-cycle latency check exact.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the banked I/O port.
// Assumes a two-bit register offset space.
package gpio_port_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        OFS_PORT  = 2'd0,
        OFS_PULL  = 2'd1,
        OFS_WOR   = 2'd2,
        OFS_SPARE = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the asynchronous pin levels.
// Assumes every bit is treated on its own (no bus coherence is needed).
module gpio_in_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift pin levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R9: the value read is the pin level from two edges earlier.
    a_r9_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
// Register file and read mux for the port.
// Offset 0 is banked between data (bank 0) and direction (bank 1).
// Offset 1 holds the pullup enables and offset 2 holds the wired-OR mode bits.
// Offset 3 is empty. Reset clears every register except the data register.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  map_sel,
    input  logic [WIDTH-1:0]      wr_data,
    input  logic [WIDTH-1:0]      pin_sync,
    input  logic [WIDTH-1:0]      claimed,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      data_q,
    output logic [WIDTH-1:0]      pull_q,
    output logic [WIDTH-1:0]      wor_q,
    output logic [WIDTH-1:0]      rd_data
);
    reg_ofs_e ofs;
    logic     wr_dir, wr_data_bank, wr_pull, wr_wor;
    logic [WIDTH-1:0] port_view;

    assign ofs = reg_ofs_e'(addr);

    // Decode which register this cycle's write goes to.
    always_comb begin
        wr_dir       = wr_en && (ofs == OFS_PORT) &&  map_sel;
        wr_data_bank = wr_en && (ofs == OFS_PORT) && !map_sel;
        wr_pull      = wr_en && (ofs == OFS_PULL);
        wr_wor       = wr_en && (ofs == OFS_WOR);
    end

    // Control registers that reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            pull_q <= '0;
            wor_q  <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wr_data;
            if (wr_pull) pull_q <= wr_data;
            if (wr_wor)  wor_q  <= wr_data;
        end
    end

    // Data register: reset leaves it alone, and writes are ignored during reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_data_bank) data_q <= wr_data;
    end

    // Data-bank view: latched value for unclaimed outputs, pin level elsewhere.
    always_comb begin
        for (int i = 0; i < int'(WIDTH); i++) begin
            port_view[i] = (dir_q[i] && !claimed[i]) ? data_q[i] : pin_sync[i];
        end
    end

    // Read mux.
    always_comb begin
        unique case (ofs)
            OFS_PORT:  rd_data = map_sel ? dir_q : port_view;
            OFS_PULL:  rd_data = pull_q;
            OFS_WOR:   rd_data = wor_q;
            default:   rd_data = '0;
        endcase
    end

    // R3: the direction register is zero on the first cycle out of reset.
    a_r3_dir_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && pull_q == '0 && wor_q == '0));
    // R2: a direction-bank write lands in the direction register.
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && map_sel) |=> (dir_q == $past(wr_data)));
    // R2: a data-bank write does not disturb the direction register.
    a_r2_bank_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && !map_sel) |=> $stable(dir_q));
    // R10: writes to the empty offset change nothing.
    a_r10_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> ($stable(dir_q) && $stable(pull_q) && $stable(wor_q)));
    // R10: the empty offset reads as zero.
    a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rd_data == '0));
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Output control for one pin: chooses between port control and subsystem
// control, applies open-drain rules and gates the pullup.
// Assumes FORCE_OD and CLAIMABLE are fixed for each pin when the design is built.
module gpio_pin_ctrl #(
    parameter bit FORCE_OD  = 1'b0,
    parameter bit CLAIMABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_bit,
    input  logic data_bit,
    input  logic pull_bit,
    input  logic wor_bit,
    input  logic claim_en,
    input  logic claim_oe,
    input  logic claim_out,
    output logic claimed,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_od,
    output logic pad_pu_en
);
    logic drive_req;
    logic drive_val;

    // Only pins in the claim mask respond to a subsystem hook.
    if (CLAIMABLE) begin : g_claim
        assign claimed = claim_en;
    end else begin : g_fixed
        logic unused_hooks;
        assign unused_hooks = claim_en ^ claim_oe ^ claim_out;
        assign claimed      = 1'b0;
    end

    // Choose the drive source and apply the open-drain and pullup rules.
    always_comb begin
        drive_req = claimed ? claim_oe  : dir_bit;
        drive_val = claimed ? claim_out : data_bit;
        pad_od    = FORCE_OD | wor_bit;
        pad_oe    = drive_req && (!pad_od || !drive_val);
        pad_out   = !pad_od && drive_val;
        pad_pu_en = pull_bit && !pad_oe;
    end

    // R5: an open-drain pin never drives high.
    a_r5_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        pad_od |-> !pad_out);
    // R5: an open-drain output holding a 1 releases the pad.
    a_r5_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od && !claimed && dir_bit && data_bit) |-> !pad_oe);
    // R7: the pullup is never on while the pad is driven.
    a_r7_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !pad_pu_en);
    // R1: an unclaimed input pin is never driven.
    a_r1_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!claimed && !dir_bit) |-> !pad_oe);
    // R8: a claimed pin whose subsystem does not request drive is released.
    a_r8_claim_released: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed && !claim_oe) |-> !pad_oe);
endmodule

// File: rtl/gpio_bank_port.sv
// Top of the banked-direction bidirectional I/O port.
// Assumes pin_in is asynchronous and that the hook inputs are synchronous
// to clk. The low OD_LOW_BITS pins are always open-drain; CLAIM_MASK picks
// which pins a subsystem may take over.
module gpio_bank_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned     WIDTH       = 8,
    parameter int unsigned     OD_LOW_BITS = 4,
    parameter logic [WIDTH-1:0] CLAIM_MASK = 8'h7F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_map_sel,
    input  logic [WIDTH-1:0]      bus_wr_data,
    output logic [WIDTH-1:0]      bus_rd_data,
    input  logic [WIDTH-1:0]      pin_in,
    input  logic [WIDTH-1:0]      hook_en,
    input  logic [WIDTH-1:0]      hook_oe,
    input  logic [WIDTH-1:0]      hook_out,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_od,
    output logic [WIDTH-1:0]      pad_pu_en
);
    logic [WIDTH-1:0] dir_q, data_q, pull_q, wor_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] claimed;

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .map_sel  (bus_map_sel),
        .wr_data  (bus_wr_data),
        .pin_sync (pin_sync),
        .claimed  (claimed),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .pull_q   (pull_q),
        .wor_q    (wor_q),
        .rd_data  (bus_rd_data)
    );

    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
        gpio_pin_ctrl #(
            .FORCE_OD  (i < int'(OD_LOW_BITS)),
            .CLAIMABLE (CLAIM_MASK[i])
        ) u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .dir_bit   (dir_q[i]),
            .data_bit  (data_q[i]),
            .pull_bit  (pull_q[i]),
            .wor_bit   (wor_q[i]),
            .claim_en  (hook_en[i]),
            .claim_oe  (hook_oe[i]),
            .claim_out (hook_out[i]),
            .claimed   (claimed[i]),
            .pad_out   (pad_out[i]),
            .pad_oe    (pad_oe[i]),
            .pad_od    (pad_od[i]),
            .pad_pu_en (pad_pu_en[i])
        );
    end

    // R3: all pads are released on the first cycle out of reset.
    a_r3_pads_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_pu_en == '0));
endmodule

// File: tb/gpio_bank_port_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_map_sel = 1'b0;
    logic [7:0] bus_wr_data = 8'h00;
    logic [7:0] bus_rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] hook_en = 8'h00, hook_oe = 8'h00, hook_out = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_od, pad_pu_en;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    gpio_bank_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_map_sel(bus_map_sel), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
        .pin_in(pin_in), .hook_en(hook_en), .hook_oe(hook_oe), .hook_out(hook_out),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu_en(pad_pu_en)
    );

    always #2.5 clk = ~clk;

    // Vector fields: dir, wor, data, pin, exp_oe, exp_out, exp_rd
    localparam logic [55:0] VEC [6] = '{
        {8'hFF, 8'h00, 8'hA5, 8'h00, 8'hFA, 8'hA0, 8'hA5},
        {8'h00, 8'h00, 8'hFF, 8'h3C, 8'h00, 8'hF0, 8'h3C},
        {8'hF0, 8'h30, 8'h5A, 8'hC3, 8'hE0, 8'h40, 8'h53},
        {8'h0F, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'h00, 8'hF0},
        {8'h3C, 8'hC0, 8'hC3, 8'h81, 8'h3C, 8'h00, 8'h81},
        {8'hAA, 8'hFF, 8'hFF, 8'h55, 8'h00, 8'h00, 8'hFF}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic m, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_map_sel = m; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic m, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_map_sel = m;
        #1 v = bus_rd_data;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3 reset state
        check("R3", "oe after reset", pad_oe, 8'h00);
        check("R3", "pullup after reset", pad_pu_en, 8'h00);
        check("R5", "od after reset", pad_od, 8'h0F);
        rd(2'd0, 1'b1, v); check("R3", "dir after reset", v, 8'h00);
        rd(2'd1, 1'b0, v); check("R3", "pull after reset", v, 8'h00);
        rd(2'd2, 1'b0, v); check("R3", "wor after reset", v, 8'h00);

        // Vector table: R1 R5 R6 R9
        foreach (VEC[k]) begin
            wr(2'd0, 1'b1, VEC[k][55:48]);
            wr(2'd2, 1'b0, VEC[k][47:40]);
            wr(2'd0, 1'b0, VEC[k][39:32]);
            pin_in = VEC[k][31:24];
            settle();
            check("R1", $sformatf("vec%0d oe", k), pad_oe, VEC[k][23:16]);
            check("R5", $sformatf("vec%0d out", k), pad_out, VEC[k][15:8]);
            check("R6", $sformatf("vec%0d od", k), pad_od, VEC[k][47:40] | 8'h0F);
            rd(2'd0, 1'b0, v); check("R9", $sformatf("vec%0d read", k), v, VEC[k][7:0]);
            rd(2'd2, 1'b0, v); check("R6", $sformatf("vec%0d wor readback", k), v, VEC[k][47:40]);
        end
        wr(2'd2, 1'b0, 8'h00);

        // R2 bank isolation
        wr(2'd0, 1'b0, 8'h11);
        wr(2'd0, 1'b1, 8'hF0);
        rd(2'd0, 1'b1, v); check("R2", "dir bank read", v, 8'hF0);
        #1 check("R2", "data kept across dir write", pad_out, 8'h10);
        wr(2'd0, 1'b0, 8'h22);
        rd(2'd0, 1'b1, v); check("R2", "dir kept across data write", v, 8'hF0);

        // R4 data survives reset
        wr(2'd0, 1'b0, 8'h96);
        wr(2'd0, 1'b1, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        #1 check("R3", "oe after second reset", pad_oe, 8'h00);
        check("R4", "data on pad after reset", pad_out, 8'h90);
        wr(2'd0, 1'b1, 8'hFF);
        rd(2'd0, 1'b0, v); check("R4", "data read after reset", v, 8'h96);

        // R7 pullup gating
        wr(2'd0, 1'b0, 8'h00);
        wr(2'd0, 1'b1, 8'h0F);
        wr(2'd1, 1'b0, 8'hFF);
        #1 check("R7", "pullup gated by drive", pad_pu_en, 8'hF0);
        rd(2'd1, 1'b0, v); check("R7", "pull readback", v, 8'hFF);
        wr(2'd1, 1'b0, 8'h00);

        // R8 subsystem claim
        wr(2'd0, 1'b1, 8'h00);
        @(negedge clk);
        hook_en = 8'hFF; hook_oe = 8'hFF; hook_out = 8'hF0;
        #1 check("R8", "claim oe", pad_oe, 8'h7F);
        check("R8", "claim out", pad_out, 8'h70);
        hook_out = 8'h0F;
        #1 check("R8", "claim od release oe", pad_oe, 8'h70);
        check("R8", "claim od out", pad_out, 8'h00);
        wr(2'd0, 1'b1, 8'hFF);
        pin_in = 8'hAA;
        settle();
        rd(2'd0, 1'b0, v); check("R8", "claimed pins read pins", v, 8'h2A);
        @(negedge clk);
        hook_en = 8'h00; hook_oe = 8'h00; hook_out = 8'h00;

        // R10 spare offset
        wr(2'd3, 1'b0, 8'hFF);
        rd(2'd3, 1'b0, v); check("R10", "spare reads zero", v, 8'h00);
        rd(2'd0, 1'b1, v); check("R10", "dir untouched by spare write", v, 8'hFF);

        // R9 synchronizer latency
        wr(2'd0, 1'b1, 8'h00);
        pin_in = 8'h00;
        settle();
        @(negedge clk); pin_in = 8'hFF; bus_addr = 2'd0; bus_map_sel = 1'b0;
        @(negedge clk); #1 check("R9", "after one edge", bus_rd_data, 8'h00);
        @(negedge clk); #1 check("R9", "after two edges", bus_rd_data, 8'hFF);

        summary();
        $finish;
    end
endmodule